// File: doc/BRIEF.md
# Leveling Handshake Timeout Monitor

This block sits beside a DRAM controller and watches the training handshakes it runs with the PHY. There are two channels, and they do not affect each other. The read channel covers read leveling and gate training. The write channel covers write leveling.

A channel's timer runs while its enable request is high and the PHY has not yet answered. If the PHY does not answer before a programmed limit, the channel raises an error flag. That flag stays set until software clears it.

Software uses a single-word register port. A write always updates both limit fields and may clear either flag. The same word is always visible on the read data output.

Each limit counts in blocks of 1024 clock cycles, so the longest window is 4095 × 1024 cycles.

Top module: `lvl_timeout_mon`

## Requirements
- R1: After reset, both limits and both error flags are zero, so `reg_rdata_o` reads 0.
- R2: A write with `reg_wr_i` high stores `reg_wdata_i[23:12]` as the read limit and `reg_wdata_i[11:0]` as the write limit. From the next cycle the read data returns them in the same positions.
- R3: Let L be the read limit, with L nonzero. Hold `rd_lvl_en_i` high with no response. After L*1024+1 rising edges `rd_err_o` goes high, and `reg_rdata_o[25]` with it. After L*1024 edges it is still low.
- R4: `gate_trn_en_i` starts and holds the read channel in exactly the same way as `rd_lvl_en_i`; the two enables are ORed.
- R5: Let L be the write limit, with L nonzero. Hold `wr_lvl_en_i` high with no response. After L*1024+1 rising edges `wr_err_o` goes high, and `reg_rdata_o[24]` with it.
- R6: A response sampled high while the channel's enable is high stops that channel. It raises no flag until the enable has been dropped and raised again.
- R7: A limit of zero turns off timeout detection for that channel.
- R8: Each flag holds until a register write puts 0 in its bit: bit 25 for read, bit 24 for write. Writing 1 to that bit leaves the flag as it was.
- R9: If a timeout and a clearing write fall on the same edge, the flag ends up set.
- R10: A channel that has timed out does not set its flag again until its enable has been low for at least one edge and raised again. This holds even if the flag was cleared in the meantime.
- R11: Dropping a channel's enable for a single edge restarts its count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_lvl_en_i | input | 1 | Read leveling enable request |
| gate_trn_en_i | input | 1 | Gate training enable request |
| rd_lvl_resp_i | input | 1 | PHY response for the read channel |
| wr_lvl_en_i | input | 1 | Write leveling enable request |
| wr_lvl_resp_i | input | 1 | PHY response for the write channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register contents: limits and flags |
| rd_err_o | output | 1 | Read channel timeout flag |
| wr_err_o | output | 1 | Write channel timeout flag |

## Verification
A timeout set and a clearing write can land on the same rising edge. The bench provokes this by first leaving a flag set from an earlier episode. It then re-arms the channel, waits 1024 edges, and drives a write with a 0 in the flag's bit so that it meets the firing edge. The flag must read 1 afterwards. A per-clock behavioural model confirms the same outcome, along with every other cycle of both channels.

// File: rtl/lvl_mon_pkg.sv
package lvl_mon_pkg;
  localparam int unsigned NUM_CH = 2;
  // Channel index also fixes field and flag positions in the register word
  typedef enum int unsigned {CH_WR = 0, CH_RD = 1} lvl_ch_e;
endpackage

// File: rtl/lvl_cfg_regs.sv
module lvl_cfg_regs #(
  parameter int unsigned LIM_W = 12,
  parameter int unsigned NCH   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [NCH*LIM_W-1:0]      wdata_i,
  output logic [NCH-1:0][LIM_W-1:0] limit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   limit_o <= '0;
    else if (wr_i) limit_o <= wdata_i;
  end
endmodule

// File: rtl/lvl_chan_timer.sv
module lvl_chan_timer #(
  parameter int unsigned PRE_W = 10,
  parameter int unsigned LIM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             resp_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             fire_o
);
  logic [PRE_W-1:0] pre_q;
  logic [LIM_W-1:0] unit_q;
  logic             done_q;   // response seen or timeout fired in this episode
  logic             busy, hit;

  assign busy   = en_i & ~resp_i & ~done_q;
  assign hit    = (limit_i != '0) && (unit_q >= limit_i);
  assign fire_o = busy & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      pre_q  <= '0;
      unit_q <= '0;
      done_q <= 1'b0;
    end else if (resp_i || fire_o) begin
      pre_q  <= '0;
      unit_q <= '0;
      done_q <= 1'b1;
    end else if (!done_q) begin
      pre_q <= pre_q + 1'b1;
      // unit counter saturates so a long run never wraps below the limit
      if ((&pre_q) && !(&unit_q)) unit_q <= unit_q + 1'b1;
    end
  end
endmodule

// File: rtl/lvl_err_flag.sv
module lvl_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/lvl_timeout_mon.sv
module lvl_timeout_mon
  import lvl_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LIM_W  = 12,
  parameter int unsigned PRE_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_lvl_en_i,
  input  logic              gate_trn_en_i,
  input  logic              rd_lvl_resp_i,
  input  logic              wr_lvl_en_i,
  input  logic              wr_lvl_resp_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rd_err_o,
  output logic              wr_err_o
);
  localparam int unsigned NCH     = NUM_CH;
  localparam int unsigned LIM_TOT = NCH * LIM_W;
  localparam int unsigned ERR_LSB = LIM_TOT;

  logic [NCH-1:0][LIM_W-1:0] limit;
  logic [NCH-1:0]            ch_en, ch_resp, ch_fire, ch_err;
  logic                      unused_wdata;

  assign ch_en[CH_WR]   = wr_lvl_en_i;
  assign ch_en[CH_RD]   = rd_lvl_en_i | gate_trn_en_i;
  assign ch_resp[CH_WR] = wr_lvl_resp_i;
  assign ch_resp[CH_RD] = rd_lvl_resp_i;
  assign unused_wdata   = ^reg_wdata_i[DATA_W-1:ERR_LSB+NCH];

  lvl_cfg_regs #(.LIM_W(LIM_W), .NCH(NCH)) cfg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i[LIM_TOT-1:0]),
    .limit_o (limit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lvl_chan_timer #(.PRE_W(PRE_W), .LIM_W(LIM_W)) tmr_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (ch_en[c]),
      .resp_i  (ch_resp[c]),
      .limit_i (limit[c]),
      .fire_o  (ch_fire[c])
    );
    lvl_err_flag flag_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ch_fire[c]),
      .clr_i  (reg_wr_i & ~reg_wdata_i[ERR_LSB+c]),
      .flag_o (ch_err[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      reg_rdata_o[c*LIM_W +: LIM_W] = limit[c];
      reg_rdata_o[ERR_LSB + c]      = ch_err[c];
    end
  end

  assign rd_err_o = ch_err[CH_RD];
  assign wr_err_o = ch_err[CH_WR];
endmodule

// File: rtl/lvl_timeout_mon_chk.sv
module lvl_timeout_mon_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LIM_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_lvl_en_i,
  input logic              gate_trn_en_i,
  input logic              rd_lvl_resp_i,
  input logic              wr_lvl_en_i,
  input logic              wr_lvl_resp_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              rd_err_o,
  input logic              wr_err_o
);
  localparam int unsigned ERR_LSB = 2 * LIM_W;
  logic rd_en;
  assign rd_en = rd_lvl_en_i | gate_trn_en_i;

  // R2
  cfg_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> reg_rdata_o[2*LIM_W-1:0] == $past(reg_wdata_i[2*LIM_W-1:0]));

  // R8
  rd_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o && !(reg_wr_i && !reg_wdata_i[ERR_LSB+1]) |=> rd_err_o);

  // R8
  wr_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o && !(reg_wr_i && !reg_wdata_i[ERR_LSB]) |=> wr_err_o);

  // R3
  rd_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_err_o && !rd_en |=> !rd_err_o);

  // R5
  wr_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_err_o && !wr_lvl_en_i |=> !wr_err_o);

  // R6
  rd_resp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_err_o && rd_lvl_resp_i |=> !rd_err_o);

  // R6
  wr_resp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_err_o && wr_lvl_resp_i |=> !wr_err_o);

  // R7
  rd_zero_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_err_o && reg_rdata_o[2*LIM_W-1:LIM_W] == '0 |=> !rd_err_o);

  // R7
  wr_zero_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_err_o && reg_rdata_o[LIM_W-1:0] == '0 |=> !wr_err_o);
endmodule

bind lvl_timeout_mon lvl_timeout_mon_chk #(.DATA_W(DATA_W), .LIM_W(LIM_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rd_lvl_en_i   (rd_lvl_en_i),
  .gate_trn_en_i (gate_trn_en_i),
  .rd_lvl_resp_i (rd_lvl_resp_i),
  .wr_lvl_en_i   (wr_lvl_en_i),
  .wr_lvl_resp_i (wr_lvl_resp_i),
  .reg_wr_i      (reg_wr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .rd_err_o      (rd_err_o),
  .wr_err_o      (wr_err_o)
);

// File: tb/lvl_timeout_mon_tb_top.sv
module lvl_timeout_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, gate_en = 1'b0, rd_resp = 1'b0;
  logic        wr_en = 1'b0, wr_resp = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic        rd_err, wr_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // model state, index 0 = write channel, 1 = read channel
  int m_cnt[2], m_lim[2];
  bit m_done[2], m_err[2];

  always #10 clk = ~clk;

  lvl_timeout_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_lvl_en_i(rd_en), .gate_trn_en_i(gate_en), .rd_lvl_resp_i(rd_resp),
    .wr_lvl_en_i(wr_en), .wr_lvl_resp_i(wr_resp),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .rd_err_o(rd_err), .wr_err_o(wr_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit en, rs, fire;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_lim[c] = 0; m_done[c] = 0; m_err[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        en = (c == 1) ? (rd_en | gate_en) : wr_en;
        rs = (c == 1) ? rd_resp : wr_resp;
        fire = 1'b0;
        if (!en) begin m_cnt[c] = 0; m_done[c] = 0; end
        else if (m_done[c]) begin end
        else if (rs) begin m_done[c] = 1; m_cnt[c] = 0; end
        else if (m_lim[c] != 0 && m_cnt[c] >= m_lim[c] * 1024) begin
          fire = 1'b1; m_done[c] = 1;
        end else m_cnt[c]++;
        if (fire) m_err[c] = 1;
        else if (reg_wr && !reg_wdata[24+c]) m_err[c] = 0;
      end
      if (reg_wr) begin
        m_lim[0] = int'(reg_wdata[11:0]);
        m_lim[1] = int'(reg_wdata[23:12]);
      end
    end
  end

  // per-clock comparison against the model (R3 R5 R8 cover)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3/R5 model rdata", rdata,
          {6'b0, m_err[1], m_err[0], m_lim[1][11:0], m_lim[0][11:0]});
      chk("R3 model rd_err", {31'b0, rd_err}, {31'b0, m_err[1]});
      chk("R5 model wr_err", {31'b0, wr_err}, {31'b0, m_err[0]});
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(int rdl, int wrl, bit rde, bit wre);
    reg_wdata = {6'b0, rde, wre, rdl[11:0], wrl[11:0]};
    reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset flags", {30'b0, rd_err, wr_err}, 32'h0);

    wr_reg(2, 1, 0, 0);
    chk("R2 limits readback", rdata, 32'h0000_2001);

    // write channel timeout, limit 1
    wr_en = 1'b1;
    step(1024);
    chk("R5 before limit", {31'b0, wr_err}, 32'h0);
    step(1);
    chk("R5 after limit", {31'b0, wr_err}, 32'h1);
    chk("R5 flag bit 24", {31'b0, rdata[24]}, 32'h1);

    wr_reg(2, 1, 0, 1);
    chk("R8 write one keeps", {31'b0, wr_err}, 32'h1);
    wr_reg(2, 1, 0, 0);
    chk("R8 write zero clears", {31'b0, wr_err}, 32'h0);
    step(2000);
    chk("R10 no refire same episode", {31'b0, wr_err}, 32'h0);

    wr_en = 1'b0; step(1); wr_en = 1'b1;
    step(1025);
    chk("R10 refire after rearm", {31'b0, wr_err}, 32'h1);

    // set and clear on the same edge
    wr_en = 1'b0; step(1); wr_en = 1'b1;
    step(1024);
    reg_wdata = {6'b0, 1'b0, 1'b0, 12'd2, 12'd1};
    reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
    chk("R9 set wins", {31'b0, wr_err}, 32'h1);
    wr_en = 1'b0;
    wr_reg(2, 1, 0, 0);
    chk("R8 clear after R9", {31'b0, wr_err}, 32'h0);

    // gate training alone drives read channel, limit 2
    gate_en = 1'b1;
    step(2048);
    chk("R4 gate before limit", {31'b0, rd_err}, 32'h0);
    step(1);
    chk("R4 gate after limit", {31'b0, rd_err}, 32'h1);
    chk("R4 flag bit 25", {31'b0, rdata[25]}, 32'h1);
    gate_en = 1'b0;
    wr_reg(2, 1, 0, 0);
    chk("R8 clear read flag", {31'b0, rd_err}, 32'h0);

    rd_en = 1'b1;
    step(2048);
    chk("R3 before limit", {31'b0, rd_err}, 32'h0);
    step(1);
    chk("R3 after limit", {31'b0, rd_err}, 32'h1);
    rd_en = 1'b0;
    wr_reg(2, 1, 0, 0);

    // response stops the read channel
    rd_en = 1'b1;
    step(500);
    rd_resp = 1'b1; step(1); rd_resp = 1'b0;
    step(4000);
    chk("R6 response blocks", {31'b0, rd_err}, 32'h0);
    rd_en = 1'b0; step(1);

    // response stops the write channel
    wr_en = 1'b1;
    step(300);
    wr_resp = 1'b1; step(1); wr_resp = 1'b0;
    step(2000);
    chk("R6 write response blocks", {31'b0, wr_err}, 32'h0);
    wr_en = 1'b0; step(1);

    // short drop restarts the count
    wr_en = 1'b1; step(1000);
    wr_en = 1'b0; step(1);
    wr_en = 1'b1; step(1000);
    chk("R11 restart no fire", {31'b0, wr_err}, 32'h0);
    step(25);
    chk("R11 fire after full window", {31'b0, wr_err}, 32'h1);
    wr_en = 1'b0;
    wr_reg(2, 1, 0, 0);

    // zero limit disables
    wr_reg(0, 0, 0, 0);
    rd_en = 1'b1; wr_en = 1'b1;
    step(6000);
    chk("R7 zero limit", {30'b0, rd_err, wr_err}, 32'h0);
    rd_en = 1'b0; wr_en = 1'b0;
    step(2);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule